// File: doc/BRIEF.md
# Control and Status Register Access Unit

This block holds and serves the control and status registers of a 32-bit RISC-V hart with floating-point and supervisor support. A combinational read port and a registered write port each take a 12-bit register address. The floating-point exception flags, the rounding mode and the combined floating-point control word are three views of one 8-bit register. The machine and supervisor status views share one storage word, and every write to it is filtered by masks. These masks depend on which extensions are enabled and on the translation-mode bit. The ISA register is read-only. The cycle, time and retired-instruction addresses return halves of 64-bit counter values supplied from outside.

The unit also resolves the rounding-mode field of a floating-point instruction. The dynamic encoding selects the stored rounding mode, and a result that is not a legal mode raises an illegal-instruction indication with its cause code. Privilege checks on register access, and the counters themselves, belong to other blocks.

Top module: `csr_unit`

## Requirements
- R1: Address 0x001 reads as the low 5 bits of the floating-point control word, zero-extended. A write there replaces those 5 bits with value bits 4:0 and leaves control-word bits 7:5 unchanged.
- R2: Address 0x002 reads control-word bits 7:5 in result bits 2:0. A write there puts value bits 2:0 into control-word bits 7:5 and leaves bits 4:0 unchanged.
- R3: A write to address 0x003 keeps value bits 7:0 as the whole control word. A read of 0x003 returns those 8 bits with all higher bits zero.
- R4: A write to the machine status address 0x300 stores the value ANDed with (0x00001888 OR the supervisor mask). The stored status word never holds a bit outside the widest possible mask 0x005DFFAA.
- R5: Extension letter L is enabled when ISA register bit (code of L minus 65) is set, so S is bit 18, V bit 21, F bit 5 and X bit 23. The supervisor mask is 0 when S is off. When S is on, the mask is 0x00580122, ORed with 0x600 if V is on, 0x6000 if F is on, 0x18000 if X is on, and 0x40000 if bit 31 of the translation register at 0x180 is set.
- R6: A write to the supervisor status address 0x100 replaces the shared status word with the value ANDed with the supervisor mask only, which clears the machine-only bits 0x1888. A read of 0x100 returns the same word as a read of 0x300.
- R7: Writes to the ISA address 0x301 have no effect. Its reads return bit 30 set, ORed with bits 29:0 of the ISA_VALUE parameter.
- R8: Addresses 0xC00, 0xC01 and 0xC02 return the low 32 bits of the cycle, time and retired-instruction inputs. Addresses 0xC80, 0xC81 and 0xC82 return the high 32 bits.
- R9: The translation register at 0x180, and the GEN_DEPTH addresses starting at GEN_BASE, store all 32 written bits. Any other unlisted address reads zero, and a write to it changes nothing.
- R10: A rounding field of 7 resolves to the stored rounding mode (control-word bits 7:5). Any other field value resolves to itself.
- R11: A resolved rounding mode above 4 sets the illegal flag and a cause of 2. A resolved mode of 0 to 4 gives flag 0 and cause 0.
- R12: After reset, every register reads zero except the ISA register. A write becomes visible to reads on the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdAddr | input | 12 | Read address |
| rdData | output | 32 | Read data (combinational) |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 12 | Write address |
| wrData | input | 32 | Write value |
| cycleCount | input | 64 | Cycle counter value |
| timeCount | input | 64 | Time counter value |
| retireCount | input | 64 | Retired-instruction counter value |
| rmField | input | 3 | Rounding field of the instruction |
| rmResolved | output | 3 | Resolved rounding mode |
| rmIllegal | output | 1 | Illegal rounding mode flag |
| rmCause | output | 4 | Cause code for the illegal flag |

## Verification
The main instance gets an ISA value with S, F, V and X all enabled, so every optional term of the supervisor mask can be seen in a status read-back, including the one switched by the translation bit. A second instance gets an ISA value without S. This shows that the supervisor mask collapses to zero, so the machine status keeps only 0x1888 and a supervisor write leaves the status word empty. The generic window is kept at its default depth of 8, which puts both of its edge addresses and both of its neighbours within reach.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam logic [11:0] ADDR_FFLAGS  = 12'h001;
  localparam logic [11:0] ADDR_FRM     = 12'h002;
  localparam logic [11:0] ADDR_FCSR    = 12'h003;
  localparam logic [11:0] ADDR_SSTATUS = 12'h100;
  localparam logic [11:0] ADDR_SATP    = 12'h180;
  localparam logic [11:0] ADDR_MSTATUS = 12'h300;
  localparam logic [11:0] ADDR_ISA     = 12'h301;
  localparam logic [11:0] ADDR_CYC_LO  = 12'hC00;
  localparam logic [11:0] ADDR_TIM_LO  = 12'hC01;
  localparam logic [11:0] ADDR_RET_LO  = 12'hC02;
  localparam logic [11:0] ADDR_CYC_HI  = 12'hC80;
  localparam logic [11:0] ADDR_TIM_HI  = 12'hC81;
  localparam logic [11:0] ADDR_RET_HI  = 12'hC82;

  localparam logic [31:0] MACH_ONLY_MASK = 32'h0000_1888;
  localparam logic [31:0] SUP_BASE_MASK  = 32'h0058_0122;
  localparam logic [31:0] SUP_VEC_MASK   = 32'h0000_0600;
  localparam logic [31:0] SUP_FP_MASK    = 32'h0000_6000;
  localparam logic [31:0] SUP_XT_MASK    = 32'h0001_8000;
  localparam logic [31:0] SUP_XLAT_MASK  = 32'h0004_0000;
  localparam logic [31:0] STATUS_WIDEST  = MACH_ONLY_MASK | SUP_BASE_MASK | SUP_VEC_MASK
                                         | SUP_FP_MASK | SUP_XT_MASK | SUP_XLAT_MASK;

  localparam logic [3:0] ILLEGAL_INSTR_CAUSE = 4'd2;
  localparam logic [2:0] RM_DYNAMIC  = 3'd7;
  localparam logic [2:0] RM_LAST_OK  = 3'd4;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_FFLAGS, SEL_FRM, SEL_FCSR, SEL_STATUS, SEL_ISA, SEL_SATP,
    SEL_CYC_LO, SEL_CYC_HI, SEL_TIM_LO, SEL_TIM_HI, SEL_RET_LO, SEL_RET_HI, SEL_GEN
  } rdSel_e;

  typedef struct packed {
    logic fflags;
    logic frm;
    logic fcsr;
    logic mstat;
    logic sstat;
    logic satp;
    logic gen;
  } wrStrobe_t;

  function automatic logic extOn(input logic [31:0] isa, input byte letter);
    return isa[5'(letter - 8'd65)];
  endfunction

  function automatic logic [31:0] supMaskOf(input logic [31:0] isa, input logic xlatBit);
    logic [31:0] m;
    m = '0;
    if (extOn(isa, "S")) begin
      m = SUP_BASE_MASK;
      if (extOn(isa, "V")) m = m | SUP_VEC_MASK;
      if (extOn(isa, "F")) m = m | SUP_FP_MASK;
      if (extOn(isa, "X")) m = m | SUP_XT_MASK;
      if (xlatBit)         m = m | SUP_XLAT_MASK;
    end
    return m;
  endfunction

endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int GEN_BASE  = 12'h340,
  parameter int GEN_DEPTH = 8,
  localparam int GEN_BITS = $clog2(GEN_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [11:0]         wrAddr,
  input  logic [11:0]         rdAddr,
  input  logic [2:0]          rmField,
  input  logic [2:0]          frmStored,
  output wrStrobe_t           strobes,
  output logic [GEN_BITS-1:0] genWrIdx,
  output logic [GEN_BITS-1:0] genRdIdx,
  output rdSel_e              rdSel,
  output logic [2:0]          rmResolved,
  output logic                rmIllegal,
  output logic [3:0]          rmCause
);

  localparam logic [12:0] GEN_LO   = 13'(GEN_BASE);
  localparam logic [12:0] GEN_HI   = 13'(GEN_BASE + GEN_DEPTH);
  localparam logic [11:0] GEN_BASE12 = 12'(GEN_BASE);

  function automatic logic inWindow(input logic [11:0] a);
    return ({1'b0, a} >= GEN_LO) && ({1'b0, a} < GEN_HI);
  endfunction

  logic [11:0] wrOffset, rdOffset;
  assign wrOffset = wrAddr - GEN_BASE12;
  assign rdOffset = rdAddr - GEN_BASE12;
  assign genWrIdx = wrOffset[GEN_BITS-1:0];
  assign genRdIdx = rdOffset[GEN_BITS-1:0];

  // write decode: at most one strobe, ISA address produces none
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (wrAddr)
        ADDR_FFLAGS:  strobes.fflags = 1'b1;
        ADDR_FRM:     strobes.frm    = 1'b1;
        ADDR_FCSR:    strobes.fcsr   = 1'b1;
        ADDR_MSTATUS: strobes.mstat  = 1'b1;
        ADDR_SSTATUS: strobes.sstat  = 1'b1;
        ADDR_SATP:    strobes.satp   = 1'b1;
        default:      strobes.gen    = inWindow(wrAddr);
      endcase
    end
  end

  // read decode
  always_comb begin
    unique case (rdAddr)
      ADDR_FFLAGS:                rdSel = SEL_FFLAGS;
      ADDR_FRM:                   rdSel = SEL_FRM;
      ADDR_FCSR:                  rdSel = SEL_FCSR;
      ADDR_MSTATUS, ADDR_SSTATUS: rdSel = SEL_STATUS;
      ADDR_ISA:                   rdSel = SEL_ISA;
      ADDR_SATP:                  rdSel = SEL_SATP;
      ADDR_CYC_LO:                rdSel = SEL_CYC_LO;
      ADDR_CYC_HI:                rdSel = SEL_CYC_HI;
      ADDR_TIM_LO:                rdSel = SEL_TIM_LO;
      ADDR_TIM_HI:                rdSel = SEL_TIM_HI;
      ADDR_RET_LO:                rdSel = SEL_RET_LO;
      ADDR_RET_HI:                rdSel = SEL_RET_HI;
      default:                    rdSel = inWindow(rdAddr) ? SEL_GEN : SEL_ZERO;
    endcase
  end

  // rounding-mode resolution
  always_comb begin
    rmResolved = (rmField == RM_DYNAMIC) ? frmStored : rmField;
    rmIllegal  = rmResolved > RM_LAST_OK;
    rmCause    = rmIllegal ? ILLEGAL_INSTR_CAUSE : 4'd0;
  end

  // R9: decoder never raises two write strobes at once
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R11: illegal only when the static field or the stored mode is out of range
  p_illegal_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    rmIllegal |-> ((rmField > RM_LAST_OK && rmField != RM_DYNAMIC) ||
                   (rmField == RM_DYNAMIC && frmStored > RM_LAST_OK)));

  // R10: a static field passes through unchanged
  p_static_field_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rmField != RM_DYNAMIC) |-> (rmResolved == rmField));

endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import csr_pkg::*;
#(
  parameter logic [31:0] ISA_VALUE = 32'h0014_112D,
  parameter int GEN_DEPTH = 8,
  localparam int GEN_BITS = $clog2(GEN_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobes,
  input  logic [GEN_BITS-1:0] genWrIdx,
  input  logic [GEN_BITS-1:0] genRdIdx,
  input  logic [31:0]         wrData,
  input  rdSel_e              rdSel,
  input  logic [63:0]         cycleCount,
  input  logic [63:0]         timeCount,
  input  logic [63:0]         retireCount,
  output logic [31:0]         rdData,
  output logic [2:0]          frmStored
);

  localparam logic [31:0] ISA_READ = 32'h4000_0000 | {2'b00, ISA_VALUE[29:0]};

  logic [7:0]  fpCtl;
  logic [31:0] statusReg;
  logic [31:0] satpReg;
  logic [31:0] genMem [GEN_DEPTH];
  logic [31:0] supMask;

  assign supMask   = supMaskOf(ISA_VALUE, satpReg[31]);
  assign frmStored = fpCtl[7:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpCtl <= '0;
    end else if (strobes.fflags) begin
      fpCtl <= {fpCtl[7:5], wrData[4:0]};
    end else if (strobes.frm) begin
      fpCtl <= {wrData[2:0], fpCtl[4:0]};
    end else if (strobes.fcsr) begin
      fpCtl <= wrData[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
    end else if (strobes.mstat) begin
      statusReg <= wrData & (MACH_ONLY_MASK | supMask);
    end else if (strobes.sstat) begin
      statusReg <= wrData & supMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) satpReg <= '0;
    else if (strobes.satp) satpReg <= wrData;
  end

  for (genvar g = 0; g < GEN_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) genMem[g] <= '0;
      else if (strobes.gen && genWrIdx == GEN_BITS'(g)) genMem[g] <= wrData;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_FFLAGS: rdData = {27'd0, fpCtl[4:0]};
      SEL_FRM:    rdData = {29'd0, fpCtl[7:5]};
      SEL_FCSR:   rdData = {24'd0, fpCtl};
      SEL_STATUS: rdData = statusReg;
      SEL_ISA:    rdData = ISA_READ;
      SEL_SATP:   rdData = satpReg;
      SEL_CYC_LO: rdData = cycleCount[31:0];
      SEL_CYC_HI: rdData = cycleCount[63:32];
      SEL_TIM_LO: rdData = timeCount[31:0];
      SEL_TIM_HI: rdData = timeCount[63:32];
      SEL_RET_LO: rdData = retireCount[31:0];
      SEL_RET_HI: rdData = retireCount[63:32];
      SEL_GEN:    rdData = genMem[genRdIdx];
      default:    rdData = '0;
    endcase
  end

  // R1: a flags write leaves the rounding mode alone
  p_flags_keep_mode_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fflags |=> fpCtl[7:5] == $past(fpCtl[7:5]));

  // R2: a rounding-mode write leaves the flags alone
  p_mode_keeps_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frm |=> fpCtl[4:0] == $past(fpCtl[4:0]));

  // R4: status storage stays inside the widest mask
  p_status_in_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & ~STATUS_WIDEST) == 32'd0);

  // R6: a supervisor-view write drops the machine-only bits
  p_sup_clears_mach_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sstat |=> (statusReg & MACH_ONLY_MASK) == 32'd0);

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter logic [31:0] ISA_VALUE = 32'h0014_112D,
  parameter int GEN_BASE  = 12'h340,
  parameter int GEN_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] rdAddr,
  output logic [31:0] rdData,
  input  logic        wrEn,
  input  logic [11:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [63:0] cycleCount,
  input  logic [63:0] timeCount,
  input  logic [63:0] retireCount,
  input  logic [2:0]  rmField,
  output logic [2:0]  rmResolved,
  output logic        rmIllegal,
  output logic [3:0]  rmCause
);

  localparam int GEN_BITS = $clog2(GEN_DEPTH);

  wrStrobe_t           strobes;
  logic [GEN_BITS-1:0] genWrIdx, genRdIdx;
  rdSel_e              rdSel;
  logic [2:0]          frmStored;

  csr_ctrl #(.GEN_BASE(GEN_BASE), .GEN_DEPTH(GEN_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rmField(rmField), .frmStored(frmStored), .strobes(strobes),
    .genWrIdx(genWrIdx), .genRdIdx(genRdIdx), .rdSel(rdSel),
    .rmResolved(rmResolved), .rmIllegal(rmIllegal), .rmCause(rmCause)
  );

  csr_datapath #(.ISA_VALUE(ISA_VALUE), .GEN_DEPTH(GEN_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .genWrIdx(genWrIdx),
    .genRdIdx(genRdIdx), .wrData(wrData), .rdSel(rdSel),
    .cycleCount(cycleCount), .timeCount(timeCount), .retireCount(retireCount),
    .rdData(rdData), .frmStored(frmStored)
  );

endmodule

// File: tb/csr_unit_tb_top.sv
module csr_unit_tb_top;

  localparam logic [31:0] ISA_FULL = 32'h00B4_112D; // S,F,V,X and others
  localparam logic [31:0] ISA_NOS  = 32'h0000_112D; // no S

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [11:0] rdAddr = '0, wrAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [63:0] cycleCount = '0, timeCount = '0, retireCount = '0;
  logic [2:0]  rmField = '0;
  logic [31:0] rdData, rdDataNoS;
  logic [2:0]  rmResolved, rmResolvedNoS;
  logic        rmIllegal, rmIllegalNoS;
  logic [3:0]  rmCause, rmCauseNoS;

  csr_unit #(.ISA_VALUE(ISA_FULL)) dut_i (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cycleCount(cycleCount), .timeCount(timeCount),
    .retireCount(retireCount), .rmField(rmField), .rmResolved(rmResolved),
    .rmIllegal(rmIllegal), .rmCause(rmCause)
  );

  csr_unit #(.ISA_VALUE(ISA_NOS)) dutNoS_i (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdDataNoS), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cycleCount(cycleCount), .timeCount(timeCount),
    .retireCount(retireCount), .rmField(rmField), .rmResolved(rmResolvedNoS),
    .rmIllegal(rmIllegalNoS), .rmCause(rmCauseNoS)
  );

  typedef struct {
    int          kind;   // 0: main read, 1: main rounding bundle, 2: no-S read
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // driver side
  task automatic wrReg(input logic [11:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = v;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expRead(input int kind, input logic [11:0] a, input logic [31:0] v, input string tag);
    item_t it;
    @(posedge clk); #1;
    rdAddr = a;
    it.kind = kind; it.exp = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expRm(input logic [2:0] f, input logic ill, input logic [3:0] cause,
                       input logic [2:0] res, input string tag);
    item_t it;
    @(posedge clk); #1;
    rmField = f;
    it.kind = 1; it.exp = {24'd0, ill, cause, res}; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      case (it.kind)
        1:       act = {24'd0, rmIllegal, rmCause, rmResolved};
        2:       act = rdDataNoS;
        default: act = rdData;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R12 reset state
    expRead(0, 12'h003, 32'h0, "R12 fcsr reset");
    expRead(0, 12'h300, 32'h0, "R12 status reset");
    expRead(0, 12'h180, 32'h0, "R12 satp reset");
    expRead(0, 12'h340, 32'h0, "R12 window reset");
    expRead(0, 12'h301, 32'h40B4_112D, "R7 isa after reset");

    // R3 whole control word
    wrReg(12'h003, 32'hFFFF_FFA5);
    expRead(0, 12'h003, 32'h0000_00A5, "R3 fcsr upper cleared");
    expRead(0, 12'h001, 32'h05, "R3 flags view");
    expRead(0, 12'h002, 32'h05, "R3 mode view");

    // R1 flags write keeps mode
    wrReg(12'h001, 32'hFFFF_FFFA);
    expRead(0, 12'h003, 32'hBA, "R1 fcsr after flags write");
    expRead(0, 12'h001, 32'h1A, "R1 flags read");

    // R2 mode write keeps flags
    wrReg(12'h002, 32'hFFFF_FFF3);
    expRead(0, 12'h002, 32'h3, "R2 mode read");
    expRead(0, 12'h003, 32'h7A, "R2 fcsr after mode write");

    // R10/R11 rounding resolution
    expRm(3'd7, 1'b0, 4'd0, 3'd3, "R10 dynamic picks stored mode");
    expRm(3'd2, 1'b0, 4'd0, 3'd2, "R10 static field");
    expRm(3'd4, 1'b0, 4'd0, 3'd4, "R11 boundary mode 4 legal");
    expRm(3'd5, 1'b1, 4'd2, 3'd5, "R11 static 5 illegal");
    wrReg(12'h002, 32'h6);
    expRm(3'd7, 1'b1, 4'd2, 3'd6, "R11 dynamic stored 6 illegal");
    expRm(3'd0, 1'b0, 4'd0, 3'd0, "R10 static zero");

    // R4/R5 machine status masks
    wrReg(12'h300, 32'hFFFF_FFFF);
    expRead(0, 12'h300, 32'h0059_FFAA, "R4 mstatus mask with S,V,F,X");
    expRead(2, 12'h300, 32'h0000_1888, "R5 no S gives machine bits only");
    expRead(0, 12'h100, 32'h0059_FFAA, "R6 sstatus reads same word");

    // R6 supervisor view write
    wrReg(12'h100, 32'hFFFF_FFFF);
    expRead(0, 12'h300, 32'h0059_E722, "R6 sstatus write uses sup mask");
    expRead(2, 12'h100, 32'h0, "R5 no S sup mask zero");

    // R5 translation bit term, R9 satp storage
    wrReg(12'h180, 32'h8000_0000);
    expRead(0, 12'h180, 32'h8000_0000, "R9 satp stores");
    wrReg(12'h100, 32'hFFFF_FFFF);
    expRead(0, 12'h100, 32'h005D_E722, "R5 satp bit31 adds 0x40000");
    wrReg(12'h300, 32'hFFFF_FFFF);
    expRead(0, 12'h300, 32'h005D_FFAA, "R4 widest mstatus mask");

    // R7 ISA read-only
    wrReg(12'h301, 32'h0);
    expRead(0, 12'h301, 32'h40B4_112D, "R7 isa write ignored");
    expRead(2, 12'h301, 32'h4000_112D, "R7 isa no S instance");

    // R8 counters
    cycleCount  = 64'h1111_2222_3333_4444;
    timeCount   = 64'h5555_6666_7777_8888;
    retireCount = 64'h9999_AAAA_BBBB_CCCC;
    expRead(0, 12'hC00, 32'h3333_4444, "R8 cycle low");
    expRead(0, 12'hC80, 32'h1111_2222, "R8 cycle high");
    expRead(0, 12'hC01, 32'h7777_8888, "R8 time low");
    expRead(0, 12'hC81, 32'h5555_6666, "R8 time high");
    expRead(0, 12'hC02, 32'hBBBB_CCCC, "R8 instret low");
    expRead(0, 12'hC82, 32'h9999_AAAA, "R8 instret high");

    // R9 window and outside
    wrReg(12'h347, 32'hDEAD_BEEF);
    wrReg(12'h340, 32'h0000_0001);
    wrReg(12'h348, 32'h1234_5678);
    wrReg(12'h33F, 32'h1234_5678);
    expRead(0, 12'h347, 32'hDEAD_BEEF, "R9 last window slot");
    expRead(0, 12'h340, 32'h0000_0001, "R9 first window slot");
    expRead(0, 12'h348, 32'h0, "R9 above window reads zero");
    expRead(0, 12'h33F, 32'h0, "R9 below window reads zero");

    // R12 write visible only after the edge
    @(posedge clk); #1;
    rdAddr = 12'h341; wrEn = 1'b1; wrAddr = 12'h341; wrData = 32'hCAFE_0001;
    begin
      item_t it;
      it.kind = 0; it.exp = 32'h0; it.tag = "R12 same-cycle read old";
      expQ.push_back(it);
    end
    @(posedge clk); #1;
    wrEn = 1'b0;
    begin
      item_t it;
      it.kind = 0; it.exp = 32'hCAFE_0001; it.tag = "R12 next-cycle read new";
      expQ.push_back(it);
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule